// File: doc/BRIEF.md
# Two-Stage Lockable Watchdog Timer

A register-mapped watchdog that catches a processor which has stopped servicing it. A down counter runs from a programmable load value. When it reaches zero the first time, the block flags an interrupt and starts the count again. If software fails to clear that interrupt before the counter reaches zero a second time, and reset has been allowed, the block raises a system reset request for a fixed number of cycles. It then returns itself to its power-on state.

Software reaches the block over a plain single-cycle register bus. The bus has a word address, a write enable, write data and combinational read data. A lock register protects the configuration against stray writes. A stall option freezes the count while a debugger holds the processor halted. One control bit routes the interrupt to either a standard line or a non-maskable line.

Register indices on `bus_addr`:
- 0: control. Bit 0 is run and interrupt enable, and can only be set. Bit 1 is reset enable. Bit 2 selects the non-maskable line.
- 1: load value.
- 2: current count, read only.
- 3: raw status, bit 0.
- 4: masked status, bit 0.
- 5: interrupt clear. Any write clears.
- 6: lock.
- 7: test. Bit 0 is the stall enable.

Top module: `wdog_two_stage`

## Requirements
- R1: After a block reset, the registers read as follows: control 0, load 0xFFFFFFFF, count 0xFFFFFFFF, lock 0, raw status 0. The outputs `irq_o`, `nmi_o` and `sys_rst_o` are all low.
- R2: The load value is L and run is set (control bit 0) by a write. The counter decrements once per cycle from L. Raw status becomes 1 exactly L+1 cycles after the enabling write. In that same cycle the count reloads to L.
- R3: A write to index 5 clears raw status and reloads the count from the load value. No reset follows, and the next first timeout comes L+1 cycles later.
- R4: Reset enable is set (control bit 1). If the counter reaches zero while raw status is still 1, `sys_rst_o` goes high L+1 cycles after the first timeout. It stays high for exactly 4 cycles. Afterwards every register reads its R1 value.
- R5: Reset enable is clear. A second zero with raw status still set gives no reset. Raw status stays 1 and the count reloads to L.
- R6: A write to the load index while running places the value in the counter at once. Writing 0 while running sets raw status in the same cycle.
- R7: Writing 0 to control bit 0 does not clear run, and control bit 0 reads 1 while running. While run is 0 the count holds.
- R8: Writing 0x1ACCE551 to index 6 unlocks the block. Any other value written there locks it, and index 6 bit 0 reads 1 when locked. While the block is locked, writes to every other index are ignored.
- R9: The test stall bit is 1 and `dbg_halt` is high: the count holds. With the stall bit 0, the count decrements even while `dbg_halt` is high.
- R10: Raw status drives `irq_o` when control bit 2 is 0, and drives `nmi_o` when it is 1. Both lines require run. Masked status (index 4) reads raw status ANDed with run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| bus_addr | input | 3 | Register index |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| dbg_halt | input | 1 | Processor halted by debugger |
| irq_o | output | 1 | Standard interrupt |
| nmi_o | output | 1 | Non-maskable interrupt |
| sys_rst_o | output | 1 | System reset request |

## Verification
The hardest state to reach from the ports is the second timeout. It needs the first interrupt left pending for a whole further load period, with reset enabled. Its outcome also depends on whether a clear arrived in time. The stimulus first runs a cleared-in-time sequence on a short load value and checks that no reset appears. It then lets the same period elapse with no clear and counts the cycles of the reset pulse. It also checks that the registers have fallen back to their reset values. Lock and stall are reached by writing the lock and test indices before enabling, so each rejected write or frozen count shows at the value register.

// File: rtl/wdog_pkg.sv
// Shared register indices and configuration record for the two-stage watchdog.
// Assumes a 3-bit word index on the register bus.
package wdog_pkg;
    localparam int unsigned REG_IDX_W = 3;

    typedef enum logic [REG_IDX_W-1:0] {
        REG_CTRL   = 3'd0,
        REG_LOAD   = 3'd1,
        REG_VALUE  = 3'd2,
        REG_RAW    = 3'd3,
        REG_MASKED = 3'd4,
        REG_CLEAR  = 3'd5,
        REG_LOCK   = 3'd6,
        REG_TEST   = 3'd7
    } wdog_reg_e;

    typedef struct packed {
        logic run;
        logic rst_en;
        logic nmi_sel;
        logic stall;
    } wdog_cfg_t;
endpackage

// File: rtl/wdog_regs.sv
// Configuration registers and write-lock for the watchdog.
// Assumes DATA_W >= 3. soft_clr returns all state to reset values.
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter logic [DATA_W-1:0] UNLOCK_KEY = 32'h1ACC_E551
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 soft_clr,
    input  logic [REG_IDX_W-1:0] bus_addr,
    input  logic                 bus_we,
    input  logic [DATA_W-1:0]    bus_wdata,
    output wdog_cfg_t            cfg,
    output logic [DATA_W-1:0]    load_q,
    output logic                 locked_q,
    output logic                 wr_load,
    output logic                 wr_clear
);
    wdog_reg_e sel;
    logic      open_wr;

    assign sel      = wdog_reg_e'(bus_addr);
    assign open_wr  = bus_we && !locked_q;
    assign wr_load  = open_wr && (sel == REG_LOAD);
    assign wr_clear = open_wr && (sel == REG_CLEAR);

    // Register update: lock always writable, others only while unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) begin
            cfg      <= '0;
            load_q   <= '1;
            locked_q <= 1'b0;
        end else begin
            if (bus_we && (sel == REG_LOCK)) begin
                locked_q <= (bus_wdata != UNLOCK_KEY);
            end
            if (open_wr) begin
                case (sel)
                    REG_CTRL: begin
                        cfg.run     <= cfg.run | bus_wdata[0];
                        cfg.rst_en  <= bus_wdata[1];
                        cfg.nmi_sel <= bus_wdata[2];
                    end
                    REG_LOAD: load_q    <= bus_wdata;
                    REG_TEST: cfg.stall <= bus_wdata[0];
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/wdog_core.sv
// Down counter and timeout sequencer: first zero sets status and reloads,
// second zero with status pending fires a reset pulse of RST_CYC cycles.
// Assumes RST_CYC >= 1. fire_done requests a whole-block return to reset.
module wdog_core #(
    parameter int unsigned CNT_W   = 32,
    parameter int unsigned RST_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             rst_en,
    input  logic             stall,
    input  logic             dbg_halt,
    input  logic             wr_load,
    input  logic             wr_clear,
    input  logic [CNT_W-1:0] wdata,
    input  logic [CNT_W-1:0] load_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             raw_q,
    output logic             fire_q,
    output logic             fire_done
);
    localparam int unsigned PW = $clog2(RST_CYC + 1);

    logic [PW-1:0] pulse_q;
    logic          active;
    logic          at_zero;

    assign active    = run && !(stall && dbg_halt) && !fire_q;
    assign at_zero   = (cnt_q == '0);
    assign fire_done = fire_q && (pulse_q == '0);

    // Counter, status and reset-pulse sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n || fire_done) begin
            cnt_q   <= '1;
            raw_q   <= 1'b0;
            fire_q  <= 1'b0;
            pulse_q <= '0;
        end else if (fire_q) begin
            pulse_q <= pulse_q - PW'(1);
        end else if (wr_clear) begin
            raw_q <= 1'b0;
            cnt_q <= load_q;
        end else if (wr_load) begin
            cnt_q <= wdata;
            if (run && (wdata == '0)) begin
                raw_q <= 1'b1;
            end
        end else if (active) begin
            if (!at_zero) begin
                cnt_q <= cnt_q - CNT_W'(1);
            end else if (!raw_q) begin
                raw_q <= 1'b1;
                cnt_q <= load_q;
            end else if (rst_en) begin
                fire_q  <= 1'b1;
                pulse_q <= PW'(RST_CYC - 1);
            end else begin
                cnt_q <= load_q;
            end
        end
    end
endmodule

// File: rtl/wdog_two_stage.sv
// Top of the two-stage lockable watchdog: register file, timeout core,
// read multiplexer and interrupt routing. Read data is combinational.
module wdog_two_stage
    import wdog_pkg::*;
#(
    parameter int unsigned CNT_W   = 32,
    parameter int unsigned RST_CYC = 4,
    parameter logic [CNT_W-1:0] UNLOCK_KEY = 32'h1ACC_E551
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [REG_IDX_W-1:0] bus_addr,
    input  logic                 bus_we,
    input  logic [CNT_W-1:0]     bus_wdata,
    output logic [CNT_W-1:0]     bus_rdata,
    input  logic                 dbg_halt,
    output logic                 irq_o,
    output logic                 nmi_o,
    output logic                 sys_rst_o
);
    wdog_cfg_t        cfg;
    logic [CNT_W-1:0] load_q;
    logic [CNT_W-1:0] cnt_q;
    logic             locked_q;
    logic             wr_load;
    logic             wr_clear;
    logic             raw_q;
    logic             fire_q;
    logic             fire_done;
    logic             run_q;
    logic             stall_q;
    logic             masked;

    assign run_q   = cfg.run;
    assign stall_q = cfg.stall;

    wdog_regs #(.DATA_W(CNT_W), .UNLOCK_KEY(UNLOCK_KEY)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_clr (fire_done),
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .bus_wdata(bus_wdata),
        .cfg      (cfg),
        .load_q   (load_q),
        .locked_q (locked_q),
        .wr_load  (wr_load),
        .wr_clear (wr_clear)
    );

    wdog_core #(.CNT_W(CNT_W), .RST_CYC(RST_CYC)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (cfg.run),
        .rst_en   (cfg.rst_en),
        .stall    (cfg.stall),
        .dbg_halt (dbg_halt),
        .wr_load  (wr_load),
        .wr_clear (wr_clear),
        .wdata    (bus_wdata),
        .load_q   (load_q),
        .cnt_q    (cnt_q),
        .raw_q    (raw_q),
        .fire_q   (fire_q),
        .fire_done(fire_done)
    );

    assign masked    = raw_q && cfg.run;
    assign irq_o     = masked && !cfg.nmi_sel;
    assign nmi_o     = masked && cfg.nmi_sel;
    assign sys_rst_o = fire_q;

    // Read multiplexer over the register indices.
    always_comb begin
        bus_rdata = '0;
        case (wdog_reg_e'(bus_addr))
            REG_CTRL:   bus_rdata[2:0] = {cfg.nmi_sel, cfg.rst_en, cfg.run};
            REG_LOAD:   bus_rdata      = load_q;
            REG_VALUE:  bus_rdata      = cnt_q;
            REG_RAW:    bus_rdata[0]   = raw_q;
            REG_MASKED: bus_rdata[0]   = masked;
            REG_LOCK:   bus_rdata[0]   = locked_q;
            REG_TEST:   bus_rdata[0]   = cfg.stall;
            default:    bus_rdata      = '0;
        endcase
    end
endmodule

// File: rtl/wdog_two_stage_chk.sv
// Property checker for wdog_two_stage, attached by bind below.
module wdog_two_stage_chk
    import wdog_pkg::*;
#(
    parameter int unsigned CNT_W   = 32,
    parameter int unsigned RST_CYC = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [REG_IDX_W-1:0] bus_addr,
    input logic                 bus_we,
    input logic                 dbg_halt,
    input logic                 irq_o,
    input logic                 nmi_o,
    input logic                 sys_rst_o,
    input logic                 run_q,
    input logic                 stall_q,
    input logic                 locked_q,
    input logic [CNT_W-1:0]     load_q,
    input logic [CNT_W-1:0]     cnt_q
);
    logic [7:0] hi_len;

    // Length of the current reset pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)         hi_len <= '0;
        else if (sys_rst_o) hi_len <= hi_len + 8'd1;
        else                hi_len <= '0;
    end

    // R4
    rst_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_rst_o) |-> (hi_len == 8'(RST_CYC)));

    // R4
    rst_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hi_len <= 8'(RST_CYC));

    // R8
    locked_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_q && bus_we && (bus_addr == REG_LOAD) && !sys_rst_o) |=> $stable(load_q));

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_q && dbg_halt && run_q && !bus_we && !sys_rst_o) |=> $stable(cnt_q));

    // R7
    run_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run_q) |-> $past(sys_rst_o));

    // R10
    irq_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o || nmi_o) |-> (run_q && !(irq_o && nmi_o)));
endmodule

bind wdog_two_stage wdog_two_stage_chk #(.CNT_W(CNT_W), .RST_CYC(RST_CYC)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .dbg_halt (dbg_halt),
    .irq_o    (irq_o),
    .nmi_o    (nmi_o),
    .sys_rst_o(sys_rst_o),
    .run_q    (run_q),
    .stall_q  (stall_q),
    .locked_q (locked_q),
    .load_q   (load_q),
    .cnt_q    (cnt_q)
);

// File: tb/test_wdog_two_stage.sv
// Self-checking bench for wdog_two_stage: vector table then directed tests.
module test_wdog_two_stage;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] KEY = 32'h1ACC_E551;
    localparam logic [2:0] A_CTRL = 3'd0, A_LOAD = 3'd1, A_VAL = 3'd2, A_RAW = 3'd3,
                           A_MSK = 3'd4, A_CLR = 3'd5, A_LOCK = 3'd6, A_TEST = 3'd7;

    typedef struct packed {
        logic [31:0] ld;
        logic [31:0] ctrl;
        logic        e_irq;
        logic        e_nmi;
    } vec_t;

    localparam vec_t VECS [3] = '{
        '{ld: 32'd3,  ctrl: 32'd1, e_irq: 1'b1, e_nmi: 1'b0},
        '{ld: 32'd7,  ctrl: 32'd5, e_irq: 1'b0, e_nmi: 1'b1},
        '{ld: 32'd20, ctrl: 32'd3, e_irq: 1'b1, e_nmi: 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        dbg_halt = 1'b0;
    logic        irq_o, nmi_o, sys_rst_o;

    int total = 0;
    int fails = 0;
    logic [31:0] rv;

    wdog_two_stage i_wdog_two_stage (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dbg_halt(dbg_halt),
        .irq_o(irq_o), .nmi_o(nmi_o), .sys_rst_o(sys_rst_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        cyc(2);
        rst_n = 1'b1;
    endtask

    initial begin
        cyc(1);
        do_reset();

        // R1 reset state
        rd(A_CTRL, rv); check("R1 ctrl", rv, 32'h0);
        rd(A_LOAD, rv); check("R1 load", rv, 32'hFFFF_FFFF);
        rd(A_VAL,  rv); check("R1 value", rv, 32'hFFFF_FFFF);
        rd(A_LOCK, rv); check("R1 lock", rv, 32'h0);
        rd(A_RAW,  rv); check("R1 raw", rv, 32'h0);
        check("R1 outputs", {29'd0, irq_o, nmi_o, sys_rst_o}, 32'h0);

        // R2 and R10: vector table of first timeouts
        foreach (VECS[i]) begin
            do_reset();
            wr(A_LOAD, VECS[i].ld);
            wr(A_CTRL, VECS[i].ctrl);
            cyc(int'(VECS[i].ld));
            rd(A_RAW, rv); check("R2 raw before timeout", rv, 32'h0);
            cyc(1);
            rd(A_RAW, rv); check("R2 raw at timeout", rv, 32'h1);
            rd(A_VAL, rv); check("R2 reloaded value", rv, VECS[i].ld);
            check("R10 irq line", {31'd0, irq_o}, {31'd0, VECS[i].e_irq});
            check("R10 nmi line", {31'd0, nmi_o}, {31'd0, VECS[i].e_nmi});
            rd(A_MSK, rv); check("R10 masked", rv, 32'h1);
        end

        // R3 cleared in time, then R4 second timeout
        do_reset();
        wr(A_LOAD, 32'd5);
        wr(A_CTRL, 32'd3);
        cyc(6);
        check("R3 first timeout irq", {31'd0, irq_o}, 32'h1);
        cyc(2);
        wr(A_CLR, 32'd0);
        check("R3 irq cleared", {31'd0, irq_o}, 32'h0);
        rd(A_VAL, rv); check("R3 reloaded on clear", rv, 32'd5);
        cyc(5);
        check("R3 no early timeout", {30'd0, irq_o, sys_rst_o}, 32'h0);
        cyc(1);
        check("R3 next first timeout", {30'd0, irq_o, sys_rst_o}, 32'h2);
        cyc(5);
        check("R4 no reset yet", {31'd0, sys_rst_o}, 32'h0);
        cyc(1);
        check("R4 reset asserted", {31'd0, sys_rst_o}, 32'h1);
        cyc(3);
        check("R4 reset still high", {31'd0, sys_rst_o}, 32'h1);
        cyc(1);
        check("R4 reset released", {31'd0, sys_rst_o}, 32'h0);
        rd(A_CTRL, rv); check("R4 ctrl back to reset", rv, 32'h0);
        rd(A_LOAD, rv); check("R4 load back to reset", rv, 32'hFFFF_FFFF);
        rd(A_VAL,  rv); check("R4 value back to reset", rv, 32'hFFFF_FFFF);

        // R5 second timeout with reset disabled
        do_reset();
        wr(A_LOAD, 32'd3);
        wr(A_CTRL, 32'd1);
        cyc(4);
        check("R5 first timeout", {31'd0, irq_o}, 32'h1);
        cyc(4);
        check("R5 no reset", {31'd0, sys_rst_o}, 32'h0);
        check("R5 irq kept", {31'd0, irq_o}, 32'h1);
        rd(A_VAL, rv); check("R5 reloaded", rv, 32'd3);

        // R7 count holds while stopped, run is set-only
        do_reset();
        wr(A_LOAD, 32'd10);
        cyc(5);
        rd(A_VAL, rv); check("R7 holds while stopped", rv, 32'd10);
        wr(A_LOAD, 32'd100);
        wr(A_CTRL, 32'd1);
        cyc(10);
        wr(A_CTRL, 32'd0);
        rd(A_CTRL, rv); check("R7 run stays set", rv, 32'h1);

        // R6 load while running, zero load raises status
        wr(A_LOAD, 32'd40);
        rd(A_VAL, rv); check("R6 immediate load", rv, 32'd40);
        check("R6 no irq yet", {31'd0, irq_o}, 32'h0);
        wr(A_LOAD, 32'd0);
        check("R6 zero load irq", {31'd0, irq_o}, 32'h1);

        // R8 lock rejects writes
        do_reset();
        wr(A_LOCK, 32'h0);
        rd(A_LOCK, rv); check("R8 locked status", rv, 32'h1);
        wr(A_LOAD, 32'h55);
        rd(A_LOAD, rv); check("R8 load write ignored", rv, 32'hFFFF_FFFF);
        wr(A_CTRL, 32'h1);
        rd(A_CTRL, rv); check("R8 ctrl write ignored", rv, 32'h0);
        wr(A_LOCK, KEY);
        rd(A_LOCK, rv); check("R8 unlocked status", rv, 32'h0);
        wr(A_LOAD, 32'h55);
        rd(A_LOAD, rv); check("R8 load write accepted", rv, 32'h55);

        // R9 stall during debug halt
        do_reset();
        wr(A_LOAD, 32'd1000);
        wr(A_TEST, 32'd1);
        dbg_halt = 1'b1;
        wr(A_CTRL, 32'd1);
        cyc(10);
        rd(A_VAL, rv); check("R9 stalled count", rv, 32'd1000);
        wr(A_TEST, 32'd0);
        cyc(10);
        rd(A_VAL, rv); check("R9 counts with stall off", rv, 32'd990);
        dbg_halt = 1'b0;

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        total++;
        fails++;
        $display("FAIL watchdog timeout actual=hung expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule